// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block is the digital back end of a nine-stage pipelined quantizer. Every stage hands over a two-bit raw code that contains one bit of redundancy. The stages of one sample resolve on successive clock edges. The block therefore passes each stage's code through its own skewed delay line, so that all nine codes of a sample line up in the same cycle. It then folds the aligned codes together with an overlap-add, in which each stage's code is shifted one place less than the code of the stage before it. The block saturates any result above the 10-bit range and registers the corrected word in straight offset binary.

The output bus can be released to high impedance for board-level test by raising a single pin. A data-valid flag marks the point from which the registered word belongs to samples taken after reset. Reset is asynchronous and active low. Its release is expected to be synchronised to the clock at chip level.

Top module: `pipe_adc_corrector`

## Requirements
- R1: The input bus carries stage k (k = 0..8) at bits [2k+1:2k]. Stages 2j and 2j+1 of a sample are presented on the j-th rising edge after that sample's first edge, so one sample occupies edges 0 to 4.
- R2: Each stage code is delayed so that all nine codes of a sample combine together. The corrected word of a sample is on the output after the 5th rising edge that follows the edge which captured its stage 0 and 1 codes, and every sample captured after reset produces exactly one word, in order.
- R3: The uncorrected result is the 11-bit sum over k of code_k × 2^(8−k).
- R4: When that sum is at most 1023 the output equals it in straight offset binary: sum 0 gives 0000000000, sum 512 gives 1000000000 (midscale) and sum 1023 gives 1111111111.
- R5: When the sum exceeds 1023 (for example 1024, or 1533 with every code equal to 3) the output is 1111111111.
- R6: While rst_n is low, every delay register and the output word are zero and dout_valid is low, from the moment reset is asserted.
- R7: After rst_n rises, dout_valid stays low for the first five rising edges, rises on the sixth and then stays high until the next reset.
- R8: While out_hiz is 1 the dout bus is high impedance. While out_hiz is 0 the bus drives the registered word. out_hiz does not affect dout_valid or the pipeline contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; everything updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_codes | input | 18 | Raw two-bit stage codes, stage k at bits [2k+1:2k] |
| out_hiz | input | 1 | 1 places dout in high impedance; tie to 0 for normal use |
| dout | output | 10 | Corrected word, straight offset binary, tri-stated by out_hiz |
| dout_valid | output | 1 | High once the output word belongs to post-reset samples |

## Verification
A driver builds the skewed stage bus from a five-deep history of samples and queues each sample's expected word when the sample's stage 0 and 1 codes go out. The corrected word is due exactly five edges later, so the monitor samples one nanosecond after each rising edge. It pops one queued item per cycle in which dout_valid is high, which forces the five-cycle latency and the in-order delivery of R2. The valid flag is checked against a count of edges since reset release: low through edge five, high from edge six. The high-impedance state is observed through a pulled-up bench net while the pipeline carries only zero words, so a pulled-up read can be told apart from a driven one.

// File: rtl/pipe_corr_pkg.sv
package pipe_corr_pkg;

  localparam int unsigned STAGES_DEF = 9;
  localparam int unsigned CODE_W_DEF = 2;
  localparam int unsigned OUT_W_DEF  = 10;

  // Two stages resolve per clock edge.
  function automatic int unsigned slot_of(input int unsigned stage);
    return stage / 2;
  endfunction

  function automatic int unsigned slots_for(input int unsigned stages);
    return (stages + 1) / 2;
  endfunction

endpackage

// File: rtl/stage_skew_align.sv
module stage_skew_align
  import pipe_corr_pkg::*;
#(
  parameter int unsigned NUM_STAGES = STAGES_DEF,
  parameter int unsigned CODE_W     = CODE_W_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_STAGES*CODE_W-1:0] raw_codes,
  output logic [NUM_STAGES*CODE_W-1:0] aligned
);

  localparam int unsigned NUM_SLOTS = slots_for(NUM_STAGES);
  localparam int unsigned LAST_LO   = (NUM_STAGES - 1) * CODE_W;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    // Stages resolved in earlier slots wait longer.
    localparam int unsigned DEPTH = NUM_SLOTS - slot_of(k);

    logic [CODE_W-1:0] sh_q [DEPTH];
    logic [CODE_W-1:0] sh_d [DEPTH];

    always_comb begin
      sh_d[0] = raw_codes[k*CODE_W +: CODE_W];
      for (int i = 1; i < DEPTH; i++) begin
        sh_d[i] = sh_q[i-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) sh_q[i] <= '0;
      end else begin
        for (int i = 0; i < DEPTH; i++) sh_q[i] <= sh_d[i];
      end
    end

    assign aligned[k*CODE_W +: CODE_W] = sh_q[DEPTH-1];
  end

  // One edge seen since reset, so a one-cycle look-back is meaningful.
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // The final stage resolves in the last slot and needs one register only.
  assert_last_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> aligned[LAST_LO +: CODE_W] == $past(raw_codes[LAST_LO +: CODE_W]));

endmodule

// File: rtl/overlap_add_clamp.sv
module overlap_add_clamp
  import pipe_corr_pkg::*;
#(
  parameter int unsigned NUM_STAGES = STAGES_DEF,
  parameter int unsigned CODE_W     = CODE_W_DEF,
  parameter int unsigned OUT_W      = OUT_W_DEF
) (
  input  logic [NUM_STAGES*CODE_W-1:0]     aligned,
  output logic [NUM_STAGES+CODE_W-1:0]     sum_raw,
  output logic                             over,
  output logic [OUT_W-1:0]                 word
);

  localparam int unsigned SUM_W = NUM_STAGES + CODE_W;
  localparam logic [SUM_W-1:0] TOP_CODE = SUM_W'((1 << OUT_W) - 1);

  always_comb begin
    sum_raw = '0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      sum_raw = sum_raw
              + (SUM_W'(aligned[k*CODE_W +: CODE_W]) << (NUM_STAGES - 1 - k));
    end
  end

  always_comb begin
    over = (sum_raw > TOP_CODE);
    word = over ? {OUT_W{1'b1}} : sum_raw[OUT_W-1:0];
  end

endmodule

// File: rtl/out_valid_track.sv
module out_valid_track #(
  parameter int unsigned LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic valid
);

  localparam int unsigned CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LAT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;

  always_comb begin
    cnt_d   = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
    valid_d = valid_q | (cnt_q == CNT_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import pipe_corr_pkg::*;
#(
  parameter int unsigned NUM_STAGES = STAGES_DEF,
  parameter int unsigned CODE_W     = CODE_W_DEF,
  parameter int unsigned OUT_W      = OUT_W_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_STAGES*CODE_W-1:0] stage_codes,
  input  logic                         out_hiz,
  output wire  [OUT_W-1:0]             dout,
  output logic                         dout_valid
);

  localparam int unsigned NUM_SLOTS = slots_for(NUM_STAGES);
  localparam int unsigned SUM_W     = NUM_STAGES + CODE_W;

  logic [NUM_STAGES*CODE_W-1:0] aligned;
  logic [SUM_W-1:0]             sum_raw;
  logic                         over;
  logic [OUT_W-1:0]             word_d, word_q;

  stage_skew_align #(
    .NUM_STAGES(NUM_STAGES),
    .CODE_W    (CODE_W)
  ) align_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_codes(stage_codes),
    .aligned  (aligned)
  );

  overlap_add_clamp #(
    .NUM_STAGES(NUM_STAGES),
    .CODE_W    (CODE_W),
    .OUT_W     (OUT_W)
  ) sum_i (
    .aligned(aligned),
    .sum_raw(sum_raw),
    .over   (over),
    .word   (word_d)
  );

  // Valid rises with the first word built entirely from post-reset codes.
  out_valid_track #(
    .LAT(NUM_SLOTS)
  ) valid_i (
    .clk  (clk),
    .rst_n(rst_n),
    .valid(dout_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign dout = out_hiz ? {OUT_W{1'bz}} : word_q;

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> word_q == {OUT_W{1'b1}});

  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !over |=> word_q == $past(sum_raw[OUT_W-1:0]));

endmodule

// File: tb/pipe_adc_corrector_tb_top.sv
module pipe_adc_corrector_tb_top;

  localparam int NST = 9;
  localparam int MAXW = 1023;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] stage_codes;
  logic        out_hiz;
  tri1  [9:0]  dout_w;
  logic        dout_valid;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  int edges = 0;

  logic [17:0] hist [5];
  int          exp_q [$];

  always #2 clk = ~clk;

  pipe_adc_corrector dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_codes(stage_codes),
    .out_hiz    (out_hiz),
    .dout       (dout_w),
    .dout_valid (dout_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R3: weighted sum of the nine stage codes.
  function automatic int raw_sum(input logic [17:0] s);
    int acc = 0;
    for (int k = 0; k < NST; k++) acc += int'(s[2*k +: 2]) << (NST - 1 - k);
    return acc;
  endfunction

  function automatic logic [17:0] mk(input int c0, input int c1, input int rest);
    logic [17:0] s;
    s[1:0] = 2'(c0);
    s[3:2] = 2'(c1);
    for (int k = 2; k < NST; k++) s[2*k +: 2] = 2'(rest);
    return s;
  endfunction

  // R1: builds the skewed bus; stage k comes from the sample started k/2 edges ago.
  task automatic feed(input logic [17:0] s);
    @(negedge clk);
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    for (int k = 0; k < NST; k++) stage_codes[2*k +: 2] = hist[k/2][2*k +: 2];
    exp_q.push_back(raw_sum(s));
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 5; i++) hist[i] = '0;
    stage_codes = '0;
  endtask

  // Monitor: scoreboard pop one item per valid word.
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      edges = 0;
    end else begin
      edges++;
      chk(dout_valid == (edges >= 6), "R7 valid timing", int'(dout_valid), int'(edges >= 6));
      if (dout_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 word without queued sample", int'(dout_w), -1);
        end else begin
          int raw;
          int e;
          raw = exp_q.pop_front();
          e = (raw > MAXW) ? MAXW : raw;
          if (out_hiz) begin
            // Pulled-up bench net reads all ones only if dout is released; data here is zero.
            chk(dout_w === 10'h3FF && e == 0, "R8 hiz", int'(dout_w), 1023);
          end else if (raw > MAXW) begin
            chk(dout_w === 10'(e), "R5 clamp (R1 R2 R3)", int'(dout_w), e);
          end else begin
            chk(dout_w === 10'(e), "R4 in range (R1 R2 R3)", int'(dout_w), e);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    out_hiz = 1'b0;
    clear_hist();
    repeat (3) @(negedge clk);
    #1;
    chk(dout_w === 10'd0, "R6 reset word", int'(dout_w), 0);
    chk(dout_valid == 1'b0, "R6 reset valid", int'(dout_valid), 0);

    @(negedge clk);
    rst_n = 1'b1;
    // Directed corner values
    exp_q.delete();
    for (int i = 0; i < 5; i++) hist[i] = '0;
    begin
      logic [17:0] s1023;
      s1023 = mk(3, 1, 1);                 // 768+128+127 = 1023
      stage_codes = '0;
      // first feed shares the release negedge
      for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = mk(0, 0, 0);
      for (int k = 0; k < NST; k++) stage_codes[2*k +: 2] = hist[k/2][2*k +: 2];
      exp_q.push_back(0);                  // R4 zero
      feed(mk(2, 0, 0));                   // R4 512 midscale
      feed(mk(1, 1, 1));                   // 511
      feed(s1023);                         // R4 top in range
      feed(mk(3, 2, 0));                   // R5 1024
      feed(mk(3, 3, 3));                   // R5 1533
      feed(mk(0, 0, 1));                   // 127
    end
    for (int i = 0; i < 150; i++) feed(18'($urandom));

    // R8: flush to zeros, then release the bus.
    repeat (6) feed('0);
    @(negedge clk) out_hiz = 1'b1;
    exp_q.push_back(0);
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = '0;
    repeat (4) feed('0);
    @(negedge clk) out_hiz = 1'b0;
    exp_q.push_back(0);
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = '0;
    repeat (3) feed('0);

    // R6: reset in the middle of traffic.
    repeat (4) feed(mk(3, 3, 2));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dout_w === 10'd0, "R6 mid-run reset word", int'(dout_w), 0);
    chk(dout_valid == 1'b0, "R6 mid-run reset valid", int'(dout_valid), 0);
    exp_q.delete();
    clear_hist();
    @(negedge clk);
    #1;
    chk(dout_w === 10'd0, "R6 held in reset", int'(dout_w), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) hist[i] = '0;
    hist[0] = mk(1, 0, 0);
    for (int k = 0; k < NST; k++) stage_codes[2*k +: 2] = hist[k/2][2*k +: 2];
    exp_q.push_back(raw_sum(hist[0]));
    for (int i = 0; i < 30; i++) feed(18'($urandom));
    repeat (6) feed('0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() <= 6, "R2 words delivered", exp_q.size(), 6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule